// File: doc/BRIEF.md
# Single-Precision Compare Unit

This execution unit sits in a 32-bit RISC pipeline and handles the floating-point compare instruction. It takes the instruction word and two single-precision operands, A and B. A 3-bit selector in the instruction picks one of seven predicates. The unit returns 0 or 1 as a 32-bit value for the destination register, together with a write strobe and that register's index.

If either operand is denormal, no comparison is made. The unit raises an exception with a fixed cause code and suppresses the register write. It also sets a sticky denormal flag. NaN operands can set a sticky invalid-operation flag, but the write still happens.

Operations enter through a valid/ready handshake and leave with a one-cycle output strobe. The `LATENCY` parameter selects one of two configurations:
- A fast one-cycle configuration that accepts one operation per cycle.
- A three-cycle configuration that holds one operation at a time.

Top module: `fp_compare_unit`

## Requirements
- R1: A word is a compare only if bits [31:26]=6'b010110, bits [10:7]=4'b0100 and bits [3:0]=0. In that case `wr_addr` carries bits [25:21]. For any other word, the strobe still comes out, with `wr_en`=0, `result`=0, no exception and no flag change.
- R2: The selector is bits [6:4], with 0=unordered, 1=less, 2=equal, 3=less-or-equal, 4=greater, 5=not-equal, 6=greater-or-equal. The ordered predicates test B against A, so "less" is true when B < A. A true predicate writes 32'h1 and a false one writes 32'h0, both with `wr_en`=1.
- R3: Ordered comparison follows real-number order: +0 equals -0, negative values sort below positive ones, and infinities sort at the ends by sign.
- R4: If either operand is NaN, unordered and not-equal give 1 and every other predicate gives 0.
- R5: `flag_inv` is set when a NaN operand is signalling (mantissa bit 22 clear), or when any NaN meets selector 1, 3, 4 or 6. This does not suppress the write.
- R6: If either operand is denormal (exponent 0, mantissa nonzero), then:
  - `result`=0 and `wr_en`=0;
  - `exc_raise`=1 with `exc_cause`=5'b00110;
  - `flag_dnz` is set and `flag_inv` is left unchanged.
  This check takes priority over every selector.
- R7: `flag_inv` and `flag_dnz` are sticky. They clear only on reset and change in the same cycle as the `out_valid` strobe of the operation that set them.
- R8: Selector 7 is reserved. It writes 0 with `wr_en`=1 and sets no flag.
- R9: With `LATENCY`=1, `in_ready` is always high. An operation accepted on clock edge n has `out_valid` high between edges n and n+1, and operations may be accepted back to back.
- R10: With `LATENCY`=3, an operation accepted on edge n has `out_valid` high between edges n+2 and n+3. `in_ready` is low between edges n and n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | Operand A (single precision) |
| op_b | input | 32 | Operand B (single precision) |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Boolean result for the destination register |
| wr_en | output | 1 | Destination write enable (qualified by out_valid) |
| wr_addr | output | 5 | Destination register index |
| exc_raise | output | 1 | Floating-point exception raised |
| exc_cause | output | 5 | Exception cause code |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_dnz | output | 1 | Sticky denormal flag |

## Verification
The bench builds two copies of the unit side by side, u0 with `LATENCY`=1 and u1 with `LATENCY`=3, and sends the same operations to both. This puts the back-to-back acceptance and the busy window of the slow build within reach. It also checks that both builds give the same results and flags. The operands mix signed zeros, infinities, quiet and signalling NaNs, denormals and random values, and every selector is used. Malformed instruction words are included as well.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int LATENCY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] instr,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [4:0]  wr_addr,
  output logic        exc_raise,
  output logic [4:0]  exc_cause,
  output logic        flag_inv,
  output logic        flag_dnz
);

  localparam logic [5:0] OPCODE = 6'b010110;
  localparam logic [4:0] DNZ_CAUSE = 5'b00110;
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

  logic is_cmp;
  logic [2:0] sel;
  logic a_nan, b_nan, a_snan, b_snan, a_dnz, b_dnz, a_zero, b_zero;
  logic any_nan, any_dnz, relational, b_lt_a, b_eq_a, pred;
  logic c_res, c_wr, c_exc, c_io;
  logic acc;
  logic [CW-1:0] cnt;
  logic ov, p_res, p_wr, p_exc, p_io;
  logic [4:0] p_addr;
  logic set_io, set_do;

  assign is_cmp = (instr[31:26] == OPCODE) && (instr[10:7] == 4'b0100) && (instr[3:0] == 4'b0000);
  assign sel = instr[6:4];

  assign a_nan  = (&op_a[30:23]) && (|op_a[22:0]);
  assign b_nan  = (&op_b[30:23]) && (|op_b[22:0]);
  assign a_snan = a_nan && !op_a[22];
  assign b_snan = b_nan && !op_b[22];
  assign a_dnz  = !(|op_a[30:23]) && (|op_a[22:0]);
  assign b_dnz  = !(|op_b[30:23]) && (|op_b[22:0]);
  assign a_zero = !(|op_a[30:0]);
  assign b_zero = !(|op_b[30:0]);

  assign any_nan = a_nan || b_nan;
  assign any_dnz = a_dnz || b_dnz;
  assign relational = (sel == 3'd1) || (sel == 3'd3) || (sel == 3'd4) || (sel == 3'd6);

  always_comb begin
    if (a_zero && b_zero)
      b_lt_a = 1'b0;
    else if (op_b[31] != op_a[31])
      b_lt_a = op_b[31];
    else if (op_b[31])
      b_lt_a = op_a[30:0] < op_b[30:0];
    else
      b_lt_a = op_b[30:0] < op_a[30:0];
  end

  assign b_eq_a = (a_zero && b_zero) || (op_a == op_b);

  always_comb begin
    unique case (sel)
      3'd0:    pred = any_nan;
      3'd1:    pred = !any_nan && b_lt_a;
      3'd2:    pred = !any_nan && b_eq_a;
      3'd3:    pred = !any_nan && (b_lt_a || b_eq_a);
      3'd4:    pred = !any_nan && !b_lt_a && !b_eq_a;
      3'd5:    pred = any_nan || !b_eq_a;
      3'd6:    pred = !any_nan && !b_lt_a;
      default: pred = 1'b0;
    endcase
  end

  assign c_wr  = is_cmp && !any_dnz;
  assign c_exc = is_cmp && any_dnz;
  assign c_res = c_wr && pred;
  assign c_io  = c_wr && (sel != 3'd7) && any_nan && (a_snan || b_snan || relational);

  assign in_ready = (LATENCY == 1) || (cnt == '0);
  assign acc = in_valid && in_ready;

  assign set_io = (LATENCY == 1) ? (acc && c_io)  : ((cnt == CW'(1)) && p_io);
  assign set_do = (LATENCY == 1) ? (acc && c_exc) : ((cnt == CW'(1)) && p_exc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ov <= 1'b0;
      p_res <= 1'b0;
      p_wr <= 1'b0;
      p_exc <= 1'b0;
      p_io <= 1'b0;
      p_addr <= '0;
      flag_inv <= 1'b0;
      flag_dnz <= 1'b0;
    end else begin
      if (acc) begin
        p_res  <= c_res;
        p_wr   <= c_wr;
        p_exc  <= c_exc;
        p_io   <= c_io;
        p_addr <= instr[25:21];
        cnt    <= CNT_LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
      ov <= (LATENCY == 1) ? acc : (cnt == CW'(1));
      flag_inv <= flag_inv || set_io;
      flag_dnz <= flag_dnz || set_do;
    end
  end

  assign out_valid = ov;
  assign result    = {31'b0, ov && p_res};
  assign wr_en     = ov && p_wr;
  assign wr_addr   = p_addr;
  assign exc_raise = ov && p_exc;
  assign exc_cause = (ov && p_exc) ? DNZ_CAUSE : 5'b00000;

  AST_NO_WR_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n) exc_raise |-> !wr_en); // R6
  AST_EXC_SETS_DNZ: assert property (@(posedge clk) disable iff (!rst_n) exc_raise |-> flag_dnz); // R6
  AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_n) flag_inv |=> flag_inv); // R7
  AST_DNZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) flag_dnz |=> flag_dnz); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (LATENCY > 1 && in_valid && in_ready) |=> !in_ready); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (LATENCY > 1 && out_valid) |=> !out_valid); // R10
  AST_FAST_READY: assert property (@(posedge clk) disable iff (!rst_n) (LATENCY == 1) |-> in_ready); // R9

endmodule

// File: tb/sim_fp_compare_unit.sv
module sim_fp_compare_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v0 = 1'b0, v1 = 1'b0;
  logic [31:0] instr = '0, op_a = '0, op_b = '0;
  logic rdy0, ov0, wr0, exc0, fi0, fd0;
  logic rdy1, ov1, wr1, exc1, fi1, fd1;
  logic [31:0] res0, res1;
  logic [4:0] addr0, addr1, cause0, cause1;
  int checks = 0, errors = 0;
  logic efi = 1'b0, efd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_compare_unit #(.LATENCY(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(rdy0), .instr(instr), .op_a(op_a), .op_b(op_b),
    .out_valid(ov0), .result(res0), .wr_en(wr0), .wr_addr(addr0), .exc_raise(exc0), .exc_cause(cause0),
    .flag_inv(fi0), .flag_dnz(fd0));

  fp_compare_unit #(.LATENCY(3)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1), .instr(instr), .op_a(op_a), .op_b(op_b),
    .out_valid(ov1), .result(res1), .wr_en(wr1), .wr_addr(addr1), .exc_raise(exc1), .exc_cause(cause1),
    .flag_inv(fi1), .flag_dnz(fd1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] sel, input logic [4:0] rd);
    return {6'b010110, rd, 5'd3, 5'd4, 4'b0100, sel, 4'b0000};
  endfunction

  // {wr, res, exc, io, dn}
  function automatic logic [4:0] model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic an, bn, asn, bsn, ad, bd, r;
    logic [2:0] op;
    longint ka, kb;
    if (!(ins[31:26] == 6'b010110 && ins[10:7] == 4'b0100 && ins[3:0] == 4'b0)) return 5'b0;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    asn = an && !a[22];
    bsn = bn && !b[22];
    ad = (a[30:23] == 0) && (a[22:0] != 0);
    bd = (b[30:23] == 0) && (b[22:0] != 0);
    op = ins[6:4];
    if (ad || bd) return 5'b00101;
    if (op == 3'd7) return 5'b10000;
    if (an || bn) begin
      r = (op == 3'd0) || (op == 3'd5);
      return {1'b1, r, 1'b0, asn || bsn || op == 3'd1 || op == 3'd3 || op == 3'd4 || op == 3'd6, 1'b0};
    end
    ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
    kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    case (op)
      3'd1: r = kb < ka;
      3'd2: r = kb == ka;
      3'd3: r = kb <= ka;
      3'd4: r = kb > ka;
      3'd5: r = kb != ka;
      3'd6: r = kb >= ka;
      default: r = 1'b0;
    endcase
    return {1'b1, r, 3'b000};
  endfunction

  function automatic logic [63:0] pk(input logic ov, input logic wr, input logic [31:0] res, input logic ex,
                                     input logic [4:0] cause, input logic [4:0] ad, input logic fi, input logic fd);
    return {17'b0, ov, wr, res, ex, cause, ad, fi, fd};
  endfunction

  task automatic run_op(input string tag, input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [4:0] m;
    logic [63:0] e;
    m = model(ins, a, b);
    efi = efi | m[1];
    efd = efd | m[0];
    e = pk(1'b1, m[4], {31'b0, m[3]}, m[2], m[2] ? 5'b00110 : 5'b0, ins[25:21], efi, efd);
    @(negedge clk);
    instr = ins; op_a = a; op_b = b; v0 = 1'b1; v1 = 1'b1;
    chk("R10 ready before accept", 64'(rdy1), 64'd1);
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    chk({tag, " fast"}, pk(ov0, wr0, res0, exc0, cause0, addr0, fi0, fd0), e);
    chk("R10 busy/no strobe at +1", {62'b0, rdy1, ov1}, 64'd0);
    @(negedge clk);
    chk("R10 busy at +2", {62'b0, rdy1, ov1}, 64'd0);
    chk("R9 strobe drops", 64'(ov0), 64'd0);
    @(negedge clk);
    chk({tag, " slow"}, pk(ov1, wr1, res1, exc1, cause1, addr1, fi1, fd1), e);
    chk("R10 ready with strobe", 64'(rdy1), 64'd1);
  endtask

  function automatic logic [31:0] rnd_val();
    logic [31:0] x;
    x = $urandom;
    case ($urandom_range(0, 7))
      0: x = {x[31], 31'b0};
      1: x = {x[31], 8'hFF, 23'b0};
      2: x = {x[31], 8'hFF, 1'b1, x[21:0]};
      3: x = {x[31], 8'hFF, 1'b0, x[21:1], 1'b1};
      4: x = {x[31], 8'h00, x[22:1], 1'b1};
      5: x = {x[31], 8'h7F, 20'b0, x[2:0]};
      default: ;
    endcase
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 R10 reset state", pk(ov0, wr0, res0, exc0, cause0, addr0, fi0, fd0) | {rdy0 ^ 1'b1, ov1, fi1, fd1},
        64'd0);
    chk("R10 ready after reset", 64'(rdy1), 64'd1);

    run_op("R2 lt B<A", mk(3'd1, 5'd9), 32'h40000000, 32'h3F800000);
    run_op("R2 gt B<A", mk(3'd4, 5'd10), 32'h40000000, 32'h3F800000);
    run_op("R2 ge equal", mk(3'd6, 5'd11), 32'h3F800000, 32'h3F800000);
    run_op("R3 +0 eq -0", mk(3'd2, 5'd12), 32'h00000000, 32'h80000000);
    run_op("R3 -inf lt +inf", mk(3'd1, 5'd13), 32'h7F800000, 32'hFF800000);
    run_op("R3 negatives", mk(3'd1, 5'd14), 32'hBF800000, 32'hC0000000);
    run_op("R8 reserved", mk(3'd7, 5'd15), 32'h40000000, 32'h3F800000);
    run_op("R1 not a compare", {6'b010111, 5'd16, 5'd3, 5'd4, 4'b0100, 3'd2, 4'b0}, 32'h0, 32'h0);
    run_op("R4 qnan eq", mk(3'd2, 5'd17), 32'h7FC00000, 32'h3F800000);
    run_op("R4 qnan ne", mk(3'd5, 5'd18), 32'h3F800000, 32'h7FC00000);
    run_op("R5 qnan lt", mk(3'd1, 5'd19), 32'h7FC00000, 32'h3F800000);
    run_op("R7 inv stays", mk(3'd2, 5'd20), 32'h3F800000, 32'h3F800000);
    run_op("R6 denormal", mk(3'd2, 5'd21), 32'h00000001, 32'h3F800000);
    run_op("R7 dnz stays", mk(3'd0, 5'd22), 32'h3F800000, 32'h3F800000);

    // R9 back to back on the fast build
    @(negedge clk);
    instr = mk(3'd1, 5'd1); op_a = 32'h40400000; op_b = 32'h40000000; v0 = 1'b1;
    @(negedge clk);
    chk("R9 first of pair", {res0, ov0, addr0}, {32'h1, 1'b1, 5'd1});
    instr = mk(3'd4, 5'd2);
    @(negedge clk);
    v0 = 1'b0;
    chk("R9 second of pair", {res0, ov0, addr0}, {32'h0, 1'b1, 5'd2});
    chk("R9 ready held", 64'(rdy0), 64'd1);

    rst_n = 1'b0;
    efi = 1'b0; efd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R7 flags cleared by reset", {60'b0, fi0, fd0, fi1, fd1}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, ins;
      a = rnd_val();
      b = ($urandom_range(0, 5) == 0) ? a : rnd_val();
      ins = mk(3'($urandom_range(0, 7)), 5'($urandom));
      if ($urandom_range(0, 15) == 0) ins = $urandom;
      run_op("R3 random", ins, a, b);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule